// File: doc/BRIEF.md
# Outstanding Transaction Limiter

This block sits between a bus manager's request logic and a memory-mapped bus that has split read and write address channels. It counts the read transactions and the write transactions that are in flight. A read is counted from the handshake on its read-address channel until the handshake of its final read-data beat. A write is counted from the handshake on its write-address channel until the handshake of its write response. When a count reaches its configured issuing capability, the block holds off new addresses of that kind. It keeps holding them off until a completion frees a slot.

The address channels use valid/ready. Address payload wires go straight from requester to bus and do not pass through the block. Only the handshake pair is gated. While a direction is below its limit, the bus-side VALID follows the requester's VALID and the requester-side READY follows the bus's READY. At the limit, both are forced low, so neither side can complete a handshake. Back-pressure from the bus is passed through unchanged. The data and response channels are only observed. Their handshakes never depend on the limiter, so data keeps returning while new addresses are issued. Both occupancy counts are exposed as plain outputs. A limit of 1 gives strict issue-then-wait behaviour.

Top module: `oslim_limiter`

## Requirements
- R1: After reset both occupancy counts are zero and both address gates are open.
- R2: A read-address handshake (bus-side VALID and READY both high at a rising edge) raises the read count by one at that edge. A write-address handshake raises the write count by one in the same way.
- R3: Only a read-data handshake with the last flag set lowers the read count by one. Read beats without the last flag, and read beats presented while the data READY is low, leave the count unchanged.
- R4: A write-response handshake lowers the write count by one.
- R5: While the read count is below RD_LIMIT, the bus read-address VALID equals the requester VALID and the requester READY equals the bus READY. While the read count equals RD_LIMIT, both are held low.
- R6: The write-address gate follows the rule of R5, using the write count and WR_LIMIT.
- R7: An address handshake and a completion of the same direction in one cycle leave that count unchanged. The gate is not closed by this coincidence.
- R8: Read traffic never changes the write count, and write traffic never changes the read count.
- R9: A count never exceeds its limit and never goes below zero.
- R10: A VALID that is held while the bus READY is low is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | input | 1 | Read address VALID from requester |
| rd_req_ready | output | 1 | Gated read address READY to requester |
| bus_ar_valid | output | 1 | Gated read address VALID to bus |
| bus_ar_ready | input | 1 | Read address READY from bus |
| wr_req_valid | input | 1 | Write address VALID from requester |
| wr_req_ready | output | 1 | Gated write address READY to requester |
| bus_aw_valid | output | 1 | Gated write address VALID to bus |
| bus_aw_ready | input | 1 | Write address READY from bus |
| bus_r_valid | input | 1 | Observed read data VALID |
| bus_r_ready | input | 1 | Observed read data READY |
| bus_r_last | input | 1 | Observed read data last-beat flag |
| bus_b_valid | input | 1 | Observed write response VALID |
| bus_b_ready | input | 1 | Observed write response READY |
| rd_count | output | $clog2(RD_LIMIT+1) | Reads in flight |
| wr_count | output | $clog2(WR_LIMIT+1) | Writes in flight |

## Verification
Two events can fall in the same cycle: a new address handshake and a completion of the same direction. The bench provokes this below the limit by presenting an accepted address together with a last read beat, or together with a write response. It then judges that the count is unchanged after the edge and that the gate stayed open during the cycle. A completion that arrives while the count sits at its limit is also driven. The bench confirms that the stalled address is not taken in that cycle and that the count drops by one.

// File: rtl/oslim_pkg.sv
package oslim_pkg;
  function automatic int occ_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/oslim_occ_counter.sv
module oslim_occ_counter #(
  parameter int LIMIT = 4,
  localparam int W = oslim_pkg::occ_width(LIMIT)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic         retire,
  output logic [W-1:0] count,
  output logic         has_room
);
  localparam logic [W-1:0] CAP = W'(LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (issue && !retire)
      count <= count + 1'b1;
    else if (retire && !issue && count != '0)
      count <= count - 1'b1;
  end

  assign has_room = (count < CAP);

  // R9: never past the capability
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);
  // R9: a completion with nothing in flight is a protocol error
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> count != '0);
  // R2: a lone issue raises the count by one
  assert_issue_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !retire) |=> count == $past(count) + 1'b1);
  // R7: an issue and a completion together leave the count unchanged
  assert_pair_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && retire) |=> $stable(count));
endmodule

// File: rtl/oslim_addr_gate.sv
module oslim_addr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic open,
  input  logic req_valid,
  output logic req_ready,
  output logic bus_valid,
  input  logic bus_ready
);
  assign bus_valid = req_valid & open;
  assign req_ready = bus_ready & open;

  // R5/R6: a closed gate lets neither side see a handshake
  assert_closed_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !open |-> !(bus_valid && bus_ready) && !(req_valid && req_ready));
endmodule

// File: rtl/oslim_limiter.sv
module oslim_limiter #(
  parameter int RD_LIMIT = 4,
  parameter int WR_LIMIT = 2,
  localparam int RD_W = oslim_pkg::occ_width(RD_LIMIT),
  localparam int WR_W = oslim_pkg::occ_width(WR_LIMIT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_req_valid,
  output logic            rd_req_ready,
  output logic            bus_ar_valid,
  input  logic            bus_ar_ready,
  input  logic            wr_req_valid,
  output logic            wr_req_ready,
  output logic            bus_aw_valid,
  input  logic            bus_aw_ready,
  input  logic            bus_r_valid,
  input  logic            bus_r_ready,
  input  logic            bus_r_last,
  input  logic            bus_b_valid,
  input  logic            bus_b_ready,
  output logic [RD_W-1:0] rd_count,
  output logic [WR_W-1:0] wr_count
);
  logic rd_room, wr_room;
  logic ar_hs, aw_hs, r_hs, rd_done, wr_done;

  assign ar_hs   = bus_ar_valid & bus_ar_ready;
  assign aw_hs   = bus_aw_valid & bus_aw_ready;
  assign r_hs    = bus_r_valid & bus_r_ready;
  assign rd_done = r_hs & bus_r_last;
  assign wr_done = bus_b_valid & bus_b_ready;

  oslim_addr_gate rd_gate (
    .clk(clk), .rst_n(rst_n), .open(rd_room),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready),
    .bus_valid(bus_ar_valid), .bus_ready(bus_ar_ready)
  );

  oslim_addr_gate wr_gate (
    .clk(clk), .rst_n(rst_n), .open(wr_room),
    .req_valid(wr_req_valid), .req_ready(wr_req_ready),
    .bus_valid(bus_aw_valid), .bus_ready(bus_aw_ready)
  );

  oslim_occ_counter #(.LIMIT(RD_LIMIT)) rd_occ (
    .clk(clk), .rst_n(rst_n), .issue(ar_hs), .retire(rd_done),
    .count(rd_count), .has_room(rd_room)
  );

  oslim_occ_counter #(.LIMIT(WR_LIMIT)) wr_occ (
    .clk(clk), .rst_n(rst_n), .issue(aw_hs), .retire(wr_done),
    .count(wr_count), .has_room(wr_room)
  );

  // R3: a beat without the last flag does not retire a read
  assert_mid_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (r_hs && !bus_r_last && !ar_hs) |=> $stable(rd_count));
  // R8: with no read events the read count holds whatever writes do
  assert_rd_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ar_hs && !rd_done) |=> $stable(rd_count));
  // R8: with no write events the write count holds
  assert_wr_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!aw_hs && !wr_done) |=> $stable(wr_count));
  // R4: a lone response lowers the write count
  assert_resp_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !aw_hs) |=> wr_count == $past(wr_count) - 1'b1);
endmodule

// File: tb/oslim_limiter_test.sv
module oslim_limiter_test;
  localparam int RDL = 4;
  localparam int WRL = 2;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req_valid = 0, bus_ar_ready = 0, wr_req_valid = 0, bus_aw_ready = 0;
  logic bus_r_valid = 0, bus_r_ready = 1, bus_r_last = 0, bus_b_valid = 0, bus_b_ready = 1;
  logic rd_req_ready, bus_ar_valid, wr_req_ready, bus_aw_valid;
  logic [2:0] rd_count;
  logic [1:0] wr_count;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  oslim_limiter #(.RD_LIMIT(RDL), .WR_LIMIT(WRL)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .bus_ar_valid(bus_ar_valid), .bus_ar_ready(bus_ar_ready),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
    .bus_aw_valid(bus_aw_valid), .bus_aw_ready(bus_aw_ready),
    .bus_r_valid(bus_r_valid), .bus_r_ready(bus_r_ready), .bus_r_last(bus_r_last),
    .bus_b_valid(bus_b_valid), .bus_b_ready(bus_b_ready),
    .rd_count(rd_count), .wr_count(wr_count)
  );

  // inputs: rv ar_rdy r_v r_last wv aw_rdy b_v | expect: arv rdrdy awv wrrdy | rd_count | wr_count
  localparam logic [15:0] VEC [N] = '{
    {7'b1100000, 4'b1100, 3'd1, 2'd0},  // 0  R2 first read issued
    {7'b1000000, 4'b1000, 3'd1, 2'd0},  // 1  R10 bus not ready
    {7'b1110000, 4'b1100, 3'd2, 2'd0},  // 2  R3 mid beat, new read
    {7'b1100110, 4'b1111, 3'd3, 2'd1},  // 3  R2 both directions
    {7'b1100110, 4'b1111, 3'd4, 2'd2},  // 4  R2 fill to limits
    {7'b1100110, 4'b0000, 3'd4, 2'd2},  // 5  R5 R6 both stalled
    {7'b1110000, 4'b0000, 3'd4, 2'd2},  // 6  R3 mid beat frees nothing
    {7'b1111000, 4'b0000, 3'd3, 2'd2},  // 7  R3 last beat at limit
    {7'b1111000, 4'b1100, 3'd3, 2'd2},  // 8  R7 read issue + retire
    {7'b0000111, 4'b0000, 3'd3, 2'd1},  // 9  R4 response at write limit
    {7'b0000111, 4'b0011, 3'd3, 2'd1},  // 10 R7 write issue + retire
    {7'b0100010, 4'b0101, 3'd3, 2'd1},  // 11 R5 ready passes with no valid
    {7'b0011001, 4'b0000, 3'd2, 2'd0},  // 12 R8 drain both
    {7'b0011000, 4'b0000, 3'd1, 2'd0},  // 13 R8 reads only
    {7'b0011000, 4'b0000, 3'd0, 2'd0},  // 14 R3 empty
    {7'b1100110, 4'b1111, 3'd1, 2'd1}   // 15 R6 reopened
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 3, 4:    return "R2";
      1:          return "R10";
      2, 6, 7, 14: return "R3";
      5, 11:      return "R5";
      8, 10:      return "R7";
      9:          return "R4";
      12, 13:     return "R8";
      default:    return "R6";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    rd_req_valid = 0; bus_ar_ready = 0; bus_r_valid = 0; bus_r_last = 0;
    wr_req_valid = 0; bus_aw_ready = 0; bus_b_valid = 0;
    bus_r_ready = 1; bus_b_ready = 1;
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: reset state
    rd_req_valid = 1; wr_req_valid = 1; bus_ar_ready = 1; bus_aw_ready = 1;
    #1;
    check("R1", "rd_count", rd_count, 0);
    check("R1", "wr_count", wr_count, 0);
    check("R1", "gates", {bus_ar_valid, rd_req_ready, bus_aw_valid, wr_req_ready}, 4'b1111);
    idle();

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      {rd_req_valid, bus_ar_ready, bus_r_valid, bus_r_last,
       wr_req_valid, bus_aw_ready, bus_b_valid} = VEC[i][15:9];
      #1;
      check(tag_of(i), $sformatf("gates v%0d", i),
            {bus_ar_valid, rd_req_ready, bus_aw_valid, wr_req_ready}, VEC[i][8:5]);
      @(posedge clk);
      #1;
      check(tag_of(i), $sformatf("rd_count v%0d", i), rd_count, VEC[i][4:2]);
      check(tag_of(i), $sformatf("wr_count v%0d", i), wr_count, VEC[i][1:0]);
    end

    // R3: last beat with READY low does not retire (rd_count 1)
    @(negedge clk);
    idle();
    bus_r_valid = 1; bus_r_last = 1; bus_r_ready = 0;
    @(posedge clk); #1;
    check("R3", "rd_count ready low", rd_count, 1);

    // R4: response with READY low does not retire (wr_count 1)
    @(negedge clk);
    idle();
    bus_b_valid = 1; bus_b_ready = 0;
    @(posedge clk); #1;
    check("R4", "wr_count ready low", wr_count, 1);

    // R6: limit-1 edge: write at 1 of 2, issue reaches limit then closes
    @(negedge clk);
    idle();
    wr_req_valid = 1; bus_aw_ready = 1;
    @(posedge clk); #1;
    check("R9", "wr_count at cap", wr_count, 2);
    @(negedge clk); #1;
    check("R6", "write gate closed", {bus_aw_valid, wr_req_ready}, 0);
    @(posedge clk); #1;
    check("R9", "wr_count stays at cap", wr_count, 2);

    // R1: reset mid-traffic clears counts
    @(negedge clk);
    idle();
    rst_n = 0;
    @(posedge clk);
    @(negedge clk) rst_n = 1;
    rd_req_valid = 1; bus_ar_ready = 1; wr_req_valid = 1; bus_aw_ready = 1;
    #1;
    check("R1", "rd_count after reset", rd_count, 0);
    check("R1", "wr_count after reset", wr_count, 0);
    check("R1", "gates after reset", {bus_ar_valid, rd_req_ready, bus_aw_valid, wr_req_ready}, 4'b1111);
    idle();

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule